// File: doc/BRIEF.md
# Multi-Channel Level and Edge Trigger

This block watches a parallel bus of logic-analyser input channels and gives one trigger pulse when a programmed condition holds on a single sample. Four configuration words set the condition. The first chooses which channels take part at all. The second marks the channels that form the condition. The third gives each of those channels either a level test or an edge test. The fourth gives the wanted state: high or low for a level channel, falling or rising for an edge channel.

Every level channel must hold its state on the same sample. At most one edge channel may be combined with them. An edge is found by comparing the current valid sample with the previous valid sample taken since arming. If the configuration contains more than one edge channel, the block flags an error and does not fire. Arming starts a search. After the block fires it stays idle until it is armed again.

Top module: `trig_unit`

## Requirements
- R1: A configuration word is written when `cfg_we_i` is high. `cfg_sel_i` selects the word: 0 is enabled channels, 1 is triggering channels, 2 is level-mode mask, 3 is polarity. Bit n of each word belongs to channel n. All words reset to zero.
- R2: A channel that is both enabled and triggering, and whose level bit is 1, is a level condition. It matches when the channel equals its polarity bit (1 = high, 0 = low).
- R3: A channel that is both enabled and triggering, and whose level bit is 0, is an edge condition. Polarity 0 asks for a rising edge (previous 0, current 1). Polarity 1 asks for a falling edge (previous 1, current 0).
- R4: The trigger fires only when every active condition is met on the same valid sample.
- R5: When more than one active edge channel exists, `cfg_err_o` is high from the cycle after the last write, and the block never fires.
- R6: A channel whose enabled bit is 0 has no effect, whatever its other bits are.
- R7: With no active triggering channel, the first valid sample after arming fires the trigger.
- R8: The first valid sample after arming can never complete an edge condition.
- R9: `trig_o` is a one-cycle pulse in the cycle after the firing sample. `armed_o` falls in that same cycle. No further pulse comes until the block is armed again.
- R10: `arm_i` sets `armed_o` in the next cycle and forgets the previous sample. A sample presented in the same cycle as `arm_i` is ignored.
- R11: Channel values are looked at only when `smp_vld_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration word select |
| cfg_data_i | input | 32 | Configuration write data |
| smp_i | input | NCH | Channel sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| arm_i | input | 1 | Start a new trigger search |
| trig_o | output | 1 | Trigger pulse |
| armed_o | output | 1 | Search in progress |
| cfg_err_o | output | 1 | More than one edge channel is configured |

## Verification
The hardest case to reach is the meeting of re-arming and edge history. A sample that arrives in the same cycle as `arm_i` must not be used as the previous value for edge detection. The stimulus drives a high level on a rising-edge channel together with `arm_i`. It then repeats that high level as the first real sample, which must not fire. Only a later low-then-high pair may fire. A second subtle case pairs an edge channel with a level channel. The edge occurs while the level is wrong, which shows that the two conditions must hold on one sample.

// File: rtl/trig_unit_pkg.sv
package trig_unit_pkg;
  localparam int CFG_W = 32;
  localparam int N_WORDS = 4;

  typedef enum logic [1:0] {
    SEL_CHAN_EN  = 2'd0,
    SEL_TRIG_EN  = 2'd1,
    SEL_LVL_MODE = 2'd2,
    SEL_POL      = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_unit_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [1:0]     sel_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] act_lvl_o,
  output logic [NCH-1:0] act_edge_o,
  output logic [NCH-1:0] pol_o,
  output logic           cfg_err_o
);
  logic [NCH-1:0] word_q [N_WORDS];

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[w] <= '0;
      else if (we_i && (sel_i == w[1:0])) word_q[w] <= data_i;
    end
  end

  logic [NCH-1:0] active;
  assign active     = word_q[SEL_CHAN_EN] & word_q[SEL_TRIG_EN];
  assign act_lvl_o  = active & word_q[SEL_LVL_MODE];
  assign act_edge_o = active & ~word_q[SEL_LVL_MODE];
  assign pol_o      = word_q[SEL_POL];

  // more-than-one detector without a full adder tree
  always_comb begin
    logic seen;
    seen      = 1'b0;
    cfg_err_o = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (act_edge_o[i]) begin
        if (seen) cfg_err_o = 1'b1;
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trig_match.sv
module trig_match #(
  parameter int NCH = 32
) (
  input  logic [NCH-1:0] smp_i,
  input  logic [NCH-1:0] prev_i,
  input  logic           prev_ok_i,
  input  logic [NCH-1:0] act_lvl_i,
  input  logic [NCH-1:0] act_edge_i,
  input  logic [NCH-1:0] pol_i,
  output logic           hit_o
);
  logic [NCH-1:0] ok;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_comb begin
      if (act_lvl_i[i])
        ok[i] = (smp_i[i] == pol_i[i]);
      else if (act_edge_i[i])
        ok[i] = prev_ok_i && (prev_i[i] == pol_i[i]) && (smp_i[i] != pol_i[i]);
      else
        ok[i] = 1'b1;
    end
  end

  assign hit_o = &ok;
endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl #(
  parameter int NCH = 32
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic           smp_vld_i,
  input  logic [NCH-1:0] smp_i,
  input  logic           hit_i,
  input  logic           cfg_err_i,
  output logic [NCH-1:0] prev_o,
  output logic           prev_ok_o,
  output logic           armed_o,
  output logic           trig_o
);
  logic take;
  assign take = armed_o && smp_vld_i && !arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o    <= '0;
      prev_ok_o <= 1'b0;
      armed_o   <= 1'b0;
      trig_o    <= 1'b0;
    end else begin
      trig_o <= 1'b0;
      if (arm_i) begin
        armed_o   <= 1'b1;
        prev_ok_o <= 1'b0;
      end else if (take) begin
        prev_o    <= smp_i;
        prev_ok_o <= 1'b1;
        if (hit_i && !cfg_err_i) begin
          armed_o <= 1'b0;
          trig_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_unit_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [1:0]       cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic [NCH-1:0]   smp_i,
  input  logic             smp_vld_i,
  input  logic             arm_i,
  output logic             trig_o,
  output logic             armed_o,
  output logic             cfg_err_o
);
  logic [NCH-1:0] act_lvl, act_edge, pol, prev;
  logic           prev_ok, hit;

  trig_cfg_regs #(.NCH(NCH)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .data_i     (cfg_data_i[NCH-1:0]),
    .act_lvl_o  (act_lvl),
    .act_edge_o (act_edge),
    .pol_o      (pol),
    .cfg_err_o  (cfg_err_o)
  );

  trig_match #(.NCH(NCH)) u_match (
    .smp_i      (smp_i),
    .prev_i     (prev),
    .prev_ok_i  (prev_ok),
    .act_lvl_i  (act_lvl),
    .act_edge_i (act_edge),
    .pol_i      (pol),
    .hit_o      (hit)
  );

  trig_ctrl #(.NCH(NCH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (arm_i),
    .smp_vld_i (smp_vld_i),
    .smp_i     (smp_i),
    .hit_i     (hit),
    .cfg_err_i (cfg_err_o),
    .prev_o    (prev),
    .prev_ok_o (prev_ok),
    .armed_o   (armed_o),
    .trig_o    (trig_o)
  );
endmodule

// File: rtl/trig_unit_chk.sv
module trig_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic arm_i,
  input logic smp_vld_i,
  input logic trig_o,
  input logic armed_o,
  input logic cfg_err_o
);
  // R9
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  // R9
  disarm_on_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !armed_o);

  // R11
  fire_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(armed_o && smp_vld_i && !arm_i));

  // R5
  no_fire_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !$past(cfg_err_o));

  // R10
  arm_sets_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (armed_o && !trig_o));
endmodule

bind trig_unit trig_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .smp_vld_i (smp_vld_i),
  .trig_o    (trig_o),
  .armed_o   (armed_o),
  .cfg_err_o (cfg_err_o)
);

// File: tb/sim_trig_unit.sv
module sim_trig_unit;
  localparam int CLK_P = 10;
  localparam int NV = 11;
  // en, trg, lvl, pol, s0, s1, expected firing sample (0 none, 1 s0, 2 s1)
  localparam logic [193:0] TBL [NV] = '{
    {32'h1, 32'h1, 32'h1, 32'h1, 32'h0, 32'h1, 2'd2},                           // R2 high
    {32'h8, 32'h8, 32'h8, 32'h0, 32'h8, 32'h0, 2'd2},                           // R2 low
    {32'h20, 32'h20, 32'h0, 32'h0, 32'h0, 32'h20, 2'd2},                        // R3 rising
    {32'h8000_0000, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h8000_0000, 32'h0, 2'd2}, // R3 falling
    {32'h1, 32'h1, 32'h0, 32'h0, 32'h1, 32'h1, 2'd0},                           // R8
    {32'h3, 32'h3, 32'h2, 32'h2, 32'h0, 32'h1, 2'd0},                           // R4 edge without level
    {32'h3, 32'h3, 32'h2, 32'h2, 32'h2, 32'h3, 2'd2},                           // R4 both
    {32'h1, 32'h3, 32'h3, 32'h3, 32'h1, 32'h1, 2'd1},                           // R6
    {32'hffff_ffff, 32'h0, 32'h0, 32'h0, 32'h1234_5678, 32'h0, 2'd1},           // R7
    {32'h3, 32'h3, 32'h0, 32'h0, 32'h0, 32'h3, 2'd0},                           // R5
    {32'hffff_0000, 32'hffff_0000, 32'hffff_0000, 32'hffff_0000, 32'hffff_0000, 32'h0, 2'd1} // R2 upper
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_data = '0;
  logic [31:0] smp = '0;
  logic        smp_vld = 1'b0;
  logic        arm = 1'b0;
  logic        trig, armed, cfg_err;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  trig_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .smp_i(smp), .smp_vld_i(smp_vld), .arm_i(arm),
    .trig_o(trig), .armed_o(armed), .cfg_err_o(cfg_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cfg_all(input logic [31:0] e, t, l, p);
    wr(2'd0, e); wr(2'd1, t); wr(2'd2, l); wr(2'd3, p);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic send(input logic [31:0] s, output logic t);
    @(negedge clk); smp = s; smp_vld = 1'b1;
    @(negedge clk); smp_vld = 1'b0; t = trig;
  endtask

  initial begin
    #(CLK_P*100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic t;
    #(CLK_P*3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check("R1 trig reset", trig, 0);
    check("R1 armed reset", armed, 0);
    check("R1 err reset", cfg_err, 0);
    // R1 zero config = no triggering channels; R11 invalid samples ignored
    do_arm();
    check("R10 armed after arm", armed, 1);
    @(negedge clk); smp = 32'hffff_ffff;
    repeat (3) begin
      @(negedge clk);
      check("R11 no fire without valid", trig, 0);
    end
    send(32'h0, t);
    check("R1 R7 zero config fires", t, 1);
    check("R9 disarmed", armed, 0);
    @(negedge clk);
    check("R9 one-cycle pulse", trig, 0);
    send(32'h0, t);
    check("R9 no refire", t, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e, tr, l, p, s0, s1;
      logic [1:0]  x;
      logic        t0, t1;
      logic [31:0] edg;
      {e, tr, l, p, s0, s1, x} = TBL[v];
      cfg_all(e, tr, l, p);
      edg = e & tr & ~l;
      check($sformatf("R5 err flag vec %0d", v), cfg_err, ($countones(edg) > 1) ? 1 : 0);
      do_arm();
      send(s0, t0);
      send(s1, t1);
      check($sformatf("R2 R3 R4 first sample vec %0d", v), t0, (x == 2'd1) ? 1 : 0);
      check($sformatf("R2 R3 R4 second sample vec %0d", v), t1, (x == 2'd2) ? 1 : 0);
    end

    // R10 sample with arm ignored, not kept as history
    cfg_all(32'h1, 32'h1, 32'h0, 32'h0);
    do_arm();
    send(32'h0, t);
    check("R3 rising low no fire", t, 0);
    @(negedge clk); arm = 1'b1; smp = 32'h1; smp_vld = 1'b1;
    @(negedge clk); arm = 1'b0; smp_vld = 1'b0;
    check("R10 arm beats sample", trig, 0);
    check("R10 still armed", armed, 1);
    send(32'h1, t);
    check("R10 R8 history cleared", t, 0);
    send(32'h0, t);
    check("R3 falling ignored for rising", t, 0);
    send(32'h1, t);
    check("R3 rising fires", t, 1);

    // R5 error clears when config fixed
    cfg_all(32'h3, 32'h3, 32'h0, 32'h0);
    check("R5 err set", cfg_err, 1);
    wr(2'd2, 32'h2);
    check("R5 err cleared", cfg_err, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule